// File: doc/BRIEF.md
# Trap Destination and Handler Vector Selector

This block sits at the trap entry point of a processor core. When a trap is pending, it gets a one-cycle request carrying the trap number, the current trap depth, the three mode bits (hypervisor, supervisor, recovery) and a flag that marks trap classes which must always be handled by the hypervisor. From these it picks one of four destinations: the recovery/reset entry, a hypervisor handler, a supervisor handler, or the error state.

For the chosen destination it computes the handler fetch address and the next two sequential fetch addresses. Each destination has its own address formula. The supervisor and hypervisor formulas use their own base-address inputs. The recovery entry uses a fixed reset base. The block also reports the previous execution level, the recorded trap number and the new trap depth, so the save logic that follows can use them.

The decision and the address arithmetic are combinational. The results are captured in one output register stage, which loads only when a request strobe is present.

Top module: `trapsel_top`

## Requirements
- R1: While reset is asserted and after its release with no request, out_valid is 0 and every data output is 0.
- R2: out_valid is 1 exactly in the cycle after a cycle with req_valid = 1. Without a request, all data outputs hold their last values.
- R3: If st_red = 1, or cur_tl = MAX_TL-1, the destination is the reset entry (out_dest = 0) with vector code 5, so out_pc = 0xFF_F000_0000 + (5 << 5) = 0xFF_F000_00A0. This takes precedence over every other rule.
- R4: Otherwise, if cur_tl >= MAX_TL, the destination is the error state (out_dest = 3). out_pc, out_npc and out_nnpc are 0, and out_new_tl equals cur_tl.
- R5: Otherwise, if cur_tl > MAX_PTL and the next level is supervisor (st_hpriv = 0 and req_hyper_class = 0), the destination is the hypervisor (out_dest = 1) with vector code 2: out_pc = (htba with bits 13:0 cleared) | 0x40.
- R6: Otherwise, the destination is the hypervisor (out_dest = 1) with the trap number as vector code when any of these holds: st_hpriv = 1, req_hyper_class = 1, or req_tt >= 384. Then out_pc = (htba with bits 13:0 cleared) | (req_tt << 5).
- R7: In all remaining cases, the destination is the supervisor (out_dest = 2). out_pc = (tba with bits 14:0 cleared) | (bit 14 set when cur_tl >= 1) | (req_tt << 5).
- R8: For every destination except the error state, out_npc = out_pc + 4 and out_nnpc = out_pc + 8.
- R9: out_tt equals req_tt for every destination. Except in the error state, out_new_tl = cur_tl + 1.
- R10: out_prev_lvl encodes the level at the time of the trap: 2 when st_hpriv = 1 (whatever st_priv is), else 1 when st_priv = 1, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle trap request strobe |
| req_tt | input | TT_W | Trap number |
| cur_tl | input | TL_W | Current trap depth |
| st_hpriv | input | 1 | Hypervisor mode bit |
| st_priv | input | 1 | Supervisor mode bit |
| st_red | input | 1 | Recovery state bit |
| req_hyper_class | input | 1 | Trap class that always goes to the hypervisor |
| tba | input | ADDR_W | Supervisor trap table base |
| htba | input | ADDR_W | Hypervisor trap table base |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_dest | output | 2 | 0 reset entry, 1 hypervisor, 2 supervisor, 3 error |
| out_pc | output | ADDR_W | Handler fetch address |
| out_npc | output | ADDR_W | Next fetch address |
| out_nnpc | output | ADDR_W | Fetch address after next |
| out_tt | output | TT_W | Recorded trap number |
| out_new_tl | output | TL_W | Trap depth after entry |
| out_prev_lvl | output | 2 | Level before the trap |

## Verification
The bench targets the trap-depth edges of the rules:
- Depth MAX_TL-1 must go to the reset entry. A wrong comparison would send the trap to a handler or to the error state.
- Depth MAX_TL must reach the error state with zeroed addresses.
- Depth MAX_PTL must stay with the supervisor, and MAX_PTL+1 must trigger the watchdog redirect. An off-by-one here would produce vector 0x40 one depth too early or too late.
- Trap numbers 383 and 384 sit on the hypervisor boundary.
- The recovery bit together with depth MAX_TL checks the precedence order.
- The bit-14 selection at depths 0 and 1 would show as an address off by 0x4000 if wrong.
- A hypervisor bit together with a deep trap must not be taken as a watchdog.

// File: rtl/trapsel_pkg.sv
package trapsel_pkg;

  typedef enum logic [1:0] {
    DST_RESET = 2'd0,
    DST_HYPER = 2'd1,
    DST_PRIV  = 2'd2,
    DST_ERROR = 2'd3
  } trap_dest_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } exec_lvl_e;

  localparam int unsigned VEC_RESET_CODE = 5;
  localparam int unsigned VEC_WDOG_CODE  = 2;
  localparam int unsigned HYPER_TT_MIN   = 384;
  localparam int unsigned VEC_SHIFT      = 5;
  localparam int unsigned INSN_BYTES     = 4;

endpackage

// File: rtl/trapsel_route.sv
module trapsel_route
  import trapsel_pkg::*;
#(
  parameter int unsigned TT_W    = 9,
  parameter int unsigned TL_W    = 3,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic [TT_W-1:0] tt,
  input  logic [TL_W-1:0] tl,
  input  logic            hpriv,
  input  logic            priv,
  input  logic            red,
  input  logic            hyper_class,
  output trap_dest_e      dest,
  output logic [TT_W-1:0] vec_code,
  output exec_lvl_e       prev_lvl
);

  logic next_hyper;
  logic tt_high;
  logic tl_red_edge;
  logic tl_full;
  logic tl_over_ptl;

  always_comb begin
    if (hpriv)      prev_lvl = LVL_HYPER;
    else if (priv)  prev_lvl = LVL_PRIV;
    else            prev_lvl = LVL_USER;
  end

  assign next_hyper  = hpriv | hyper_class;
  assign tt_high     = (32'(tt) >= HYPER_TT_MIN);
  assign tl_red_edge = (32'(tl) == (MAX_TL - 1));
  assign tl_full     = (32'(tl) >= MAX_TL);
  assign tl_over_ptl = (32'(tl) > MAX_PTL);

  always_comb begin
    dest     = DST_PRIV;
    vec_code = tt;
    if (red || tl_red_edge) begin
      dest     = DST_RESET;
      vec_code = TT_W'(VEC_RESET_CODE);
    end else if (tl_full) begin
      dest     = DST_ERROR;
      vec_code = '0;
    end else if (tl_over_ptl && !next_hyper) begin
      dest     = DST_HYPER;
      vec_code = TT_W'(VEC_WDOG_CODE);
    end else if (next_hyper || tt_high) begin
      dest     = DST_HYPER;
      vec_code = tt;
    end
  end

endmodule

// File: rtl/trapsel_vecgen.sv
module trapsel_vecgen
  import trapsel_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned TT_W   = 9,
  parameter int unsigned TL_W   = 3,
  parameter logic [ADDR_W-1:0] RSTV_BASE = ADDR_W'(40'hFF_F000_0000)
) (
  input  trap_dest_e        dest,
  input  logic [TT_W-1:0]   vec_code,
  input  logic [TL_W-1:0]   tl,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc
);

  localparam int unsigned OFF_W = TT_W + VEC_SHIFT;
  localparam logic [ADDR_W-1:0] HYP_LOW  = (ADDR_W'(1) << OFF_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PRV_LOW  = (ADDR_W'(1) << (OFF_W + 1)) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] NEST_BIT = ADDR_W'(1) << OFF_W;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] vec_off;
  logic [ADDR_W-1:0] hyp_pc;
  logic [ADDR_W-1:0] prv_pc;
  logic [ADDR_W-1:0] rst_pc;

  assign vec_off = (ADDR_W'(vec_code) << VEC_SHIFT) & HYP_LOW;
  assign hyp_pc  = (htba & ~HYP_LOW) | vec_off;
  assign prv_pc  = (tba & ~PRV_LOW) | ((tl != '0) ? NEST_BIT : '0) | vec_off;
  assign rst_pc  = RSTV_BASE + vec_off;

  always_comb begin
    unique case (dest)
      DST_RESET: pc = rst_pc;
      DST_HYPER: pc = hyp_pc;
      DST_PRIV:  pc = prv_pc;
      default:   pc = '0;
    endcase
    if (dest == DST_ERROR) begin
      npc  = '0;
      nnpc = '0;
    end else begin
      npc  = pc + STEP;
      nnpc = pc + STEP + STEP;
    end
  end

endmodule

// File: rtl/trapsel_top.sv
module trapsel_top
  import trapsel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned TL_W    = 3,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TT_W-1:0]   req_tt,
  input  logic [TL_W-1:0]   cur_tl,
  input  logic              st_hpriv,
  input  logic              st_priv,
  input  logic              st_red,
  input  logic              req_hyper_class,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic              out_valid,
  output logic [1:0]        out_dest,
  output logic [ADDR_W-1:0] out_pc,
  output logic [ADDR_W-1:0] out_npc,
  output logic [ADDR_W-1:0] out_nnpc,
  output logic [TT_W-1:0]   out_tt,
  output logic [TL_W-1:0]   out_new_tl,
  output logic [1:0]        out_prev_lvl
);

  trap_dest_e        c_dest;
  logic [TT_W-1:0]   c_vec;
  exec_lvl_e         c_lvl;
  logic [ADDR_W-1:0] c_pc, c_npc, c_nnpc;
  logic [TL_W-1:0]   c_new_tl;

  trapsel_route #(
    .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) route_i (
    .tt(req_tt), .tl(cur_tl), .hpriv(st_hpriv), .priv(st_priv),
    .red(st_red), .hyper_class(req_hyper_class),
    .dest(c_dest), .vec_code(c_vec), .prev_lvl(c_lvl)
  );

  trapsel_vecgen #(
    .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W)
  ) vecgen_i (
    .dest(c_dest), .vec_code(c_vec), .tl(cur_tl), .tba(tba), .htba(htba),
    .pc(c_pc), .npc(c_npc), .nnpc(c_nnpc)
  );

  assign c_new_tl = (c_dest == DST_ERROR) ? cur_tl : cur_tl + TL_W'(1);

  // next-state
  logic              d_valid;
  logic [1:0]        d_dest, d_lvl;
  logic [ADDR_W-1:0] d_pc, d_npc, d_nnpc;
  logic [TT_W-1:0]   d_tt;
  logic [TL_W-1:0]   d_tl;
  logic              ld_en;

  assign ld_en = req_valid;

  always_comb begin
    d_valid = req_valid;
    d_dest  = out_dest;
    d_lvl   = out_prev_lvl;
    d_pc    = out_pc;
    d_npc   = out_npc;
    d_nnpc  = out_nnpc;
    d_tt    = out_tt;
    d_tl    = out_new_tl;
    if (ld_en) begin
      d_dest = c_dest;
      d_lvl  = c_lvl;
      d_pc   = c_pc;
      d_npc  = c_npc;
      d_nnpc = c_nnpc;
      d_tt   = req_tt;
      d_tl   = c_new_tl;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_dest     <= '0;
      out_prev_lvl <= '0;
      out_pc       <= '0;
      out_npc      <= '0;
      out_nnpc     <= '0;
      out_tt       <= '0;
      out_new_tl   <= '0;
    end else begin
      out_valid    <= d_valid;
      out_dest     <= d_dest;
      out_prev_lvl <= d_lvl;
      out_pc       <= d_pc;
      out_npc      <= d_npc;
      out_nnpc     <= d_nnpc;
      out_tt       <= d_tt;
      out_new_tl   <= d_tl;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_pc) && $stable(out_dest));
  p_red_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && st_red) |=> (out_dest == 2'(DST_RESET)));
  p_error_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dest == 2'(DST_ERROR)) |-> (out_pc == '0 && out_npc == '0));
  p_npc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dest != 2'(DST_ERROR)) |-> (out_npc == out_pc + ADDR_W'(4)));
  p_tt_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_tt == $past(req_tt)));

endmodule

// File: tb/trapsel_tb.sv
module trapsel_top_tb_top;

  localparam int ADDR_W = 64;
  localparam int TT_W   = 9;
  localparam int TL_W   = 3;

  logic clk = 0;
  logic rst_n;
  logic req_valid;
  logic [TT_W-1:0] req_tt;
  logic [TL_W-1:0] cur_tl;
  logic st_hpriv, st_priv, st_red, req_hyper_class;
  logic [ADDR_W-1:0] tba, htba;
  logic out_valid;
  logic [1:0] out_dest, out_prev_lvl;
  logic [ADDR_W-1:0] out_pc, out_npc, out_nnpc;
  logic [TT_W-1:0] out_tt;
  logic [TL_W-1:0] out_new_tl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  trapsel_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tt(req_tt),
    .cur_tl(cur_tl), .st_hpriv(st_hpriv), .st_priv(st_priv), .st_red(st_red),
    .req_hyper_class(req_hyper_class), .tba(tba), .htba(htba),
    .out_valid(out_valid), .out_dest(out_dest), .out_pc(out_pc),
    .out_npc(out_npc), .out_nnpc(out_nnpc), .out_tt(out_tt),
    .out_new_tl(out_new_tl), .out_prev_lvl(out_prev_lvl)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_case(input string req, input int tt, input int tl,
                          input bit hp, input bit pr, input bit rd, input bit hc);
    logic [63:0] e_pc, e_npc, e_nnpc;
    int e_dest, e_tl, e_lvl;
    logic [63:0] hm, tm;
    hm = htba & ~64'h3FFF;
    tm = tba & ~64'h7FFF;
    if (rd || tl == 5) begin
      e_dest = 0; e_pc = 64'hFF_F000_00A0;
    end else if (tl >= 6) begin
      e_dest = 3; e_pc = 0;
    end else if (tl > 2 && !hp && !hc) begin
      e_dest = 1; e_pc = hm | 64'h40;
    end else if (hp || hc || tt >= 384) begin
      e_dest = 1; e_pc = hm | (64'(tt) << 5);
    end else begin
      e_dest = 2; e_pc = tm | ((tl != 0) ? 64'h4000 : 0) | (64'(tt) << 5);
    end
    e_npc  = (e_dest == 3) ? 0 : e_pc + 4;
    e_nnpc = (e_dest == 3) ? 0 : e_pc + 8;
    e_tl   = (e_dest == 3) ? tl : tl + 1;
    e_lvl  = hp ? 2 : (pr ? 1 : 0);
    @(negedge clk);
    req_valid = 1; req_tt = TT_W'(tt); cur_tl = TL_W'(tl);
    st_hpriv = hp; st_priv = pr; st_red = rd; req_hyper_class = hc;
    @(negedge clk);
    req_valid = 0;
    chk("R2", {req, " valid"}, 64'(out_valid), 64'd1);
    chk(req, "dest", 64'(out_dest), 64'(e_dest));
    chk(req, "pc", out_pc, e_pc);
    chk("R8", {req, " npc"}, out_npc, e_npc);
    chk("R8", {req, " nnpc"}, out_nnpc, e_nnpc);
    chk("R9", {req, " tt"}, 64'(out_tt), 64'(tt));
    chk("R9", {req, " new_tl"}, 64'(out_new_tl), 64'(e_tl));
    chk("R10", {req, " prev_lvl"}, 64'(out_prev_lvl), 64'(e_lvl));
  endtask

  task automatic t_reset_state;
    chk("R1", "valid", 64'(out_valid), 0);
    chk("R1", "pc", out_pc, 0);
    chk("R1", "dest", 64'(out_dest), 0);
  endtask

  task automatic t_hold;
    logic [63:0] pc0;
    logic [1:0] d0;
    pc0 = out_pc; d0 = out_dest;
    req_tt = 9'h1FF; cur_tl = 3'd6; st_red = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "valid idle", 64'(out_valid), 0);
    chk("R2", "pc held", out_pc, pc0);
    chk("R2", "dest held", 64'(out_dest), 64'(d0));
    st_red = 0;
  endtask

  task automatic t_priv;
    run_case("R7", 'h024, 0, 0, 0, 0, 0);
    run_case("R7", 'h041, 1, 0, 1, 0, 0);
    run_case("R7", 383, 1, 0, 1, 0, 0);
    run_case("R7", 'h030, 2, 0, 0, 0, 0);
  endtask

  task automatic t_hyper;
    run_case("R6", 'h010, 0, 1, 1, 0, 0);
    run_case("R6", 'h008, 1, 0, 0, 0, 1);
    run_case("R6", 384, 1, 0, 1, 0, 0);
    run_case("R6", 'h05E, 4, 1, 0, 0, 0);
  endtask

  task automatic t_wdog;
    run_case("R5", 'h024, 3, 0, 1, 0, 0);
    run_case("R5", 'h1A0, 4, 0, 0, 0, 0);
  endtask

  task automatic t_red;
    run_case("R3", 'h024, 0, 0, 1, 1, 0);
    run_case("R3", 'h100, 5, 1, 0, 0, 1);
    run_case("R3", 'h041, 6, 0, 0, 1, 0);
  endtask

  task automatic t_error;
    run_case("R4", 'h024, 6, 0, 1, 0, 0);
    run_case("R4", 'h0C0, 7, 1, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_tt = 0; cur_tl = 0;
    st_hpriv = 0; st_priv = 0; st_red = 0; req_hyper_class = 0;
    tba  = 64'h0000_1234_5678_9ABC;
    htba = 64'h0000_ABCD_0000_7FFF;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_priv();
    t_hold();
    t_hyper();
    t_wdog();
    t_red();
    t_error();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule